// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block is the hazard control of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Every cycle it issues one command to each of the four inter-stage registers (fetch/decode, decode/execute, execute/memory, memory/write-back): transfer (load the next state), stall (keep the current state) or bubble (clear to all zeros, which the datapath treats as a no-op). It also tells the program counter whether to hold, and whether to load the branch target.

The controller reads the two source register fields of the instruction sitting in decode and compares them with the destinations still pending in execute and memory. With full forwarding in place (the default), only a load in execute whose result is needed by the very next instruction forces an interlock: one cycle in which fetch and decode hold and execute receives a bubble. Branches are predicted not taken. When the memory stage reports a taken branch, the three younger instructions in fetch, decode and execute are cancelled and fetch restarts at the target. Without forwarding (`BYPASS = 0`), any match with a pending writer in execute or memory interlocks.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Command code 2'b00 is transfer, 2'b01 is stall, 2'b10 is bubble. While `rst_n` is low, all four register commands are bubble, `pc_hold` is 1 and `pc_redirect` is 0.
- R2: When `ex_wr` and `ex_load` are both 1 and `ex_dst` equals source A (instruction bits [25:21]) with `id_reads_a` set, and no taken branch is present, fetch/decode gets stall, decode/execute gets bubble, the other two get transfer, `pc_hold` is 1.
- R3: Source B (instruction bits [20:16]) takes part in the comparison only while `id_reads_b` is 1, i.e. for register-register format and address-base reads; with `id_reads_b` at 0 a match on B causes no stall.
- R4: A pending destination equal to register 31 never causes a stall.
- R5: With `BYPASS = 1`, a non-load writer in execute, or any writer in memory, causes no stall.
- R6: When `mem_branch` and `mem_taken` are both 1, fetch/decode, decode/execute and execute/memory get bubble, memory/write-back gets transfer, `pc_redirect` is 1 and `pc_hold` is 0.
- R7: A branch in memory with `mem_taken` at 0 causes no stall and no bubble.
- R8: A taken branch overrides a load-use interlock in the same cycle: the R6 pattern is produced.
- R9: Out of reset and with no hazard and no taken branch, all four commands are transfer and both program-counter controls are 0; memory/write-back is never stalled or bubbled out of reset.
- R10: With `BYPASS = 0`, a match between an active source and a non-zero destination of any writer in execute or memory gives the R2 interlock pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the bound checker |
| rst_n | input | 1 | Active-low reset; forces all bubbles |
| id_instr | input | IW | Instruction word held in decode |
| id_reads_a | input | 1 | Decode instruction reads source A |
| id_reads_b | input | 1 | Decode instruction reads source B |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| ex_dst | input | REG_W | Destination of the instruction in execute |
| mem_wr | input | 1 | Instruction in memory writes a register |
| mem_dst | input | REG_W | Destination of the instruction in memory |
| mem_branch | input | 1 | Instruction in memory is a conditional branch |
| mem_taken | input | 1 | Branch condition in memory evaluated true |
| cmd_ifid | output | 2 | Command for fetch/decode register |
| cmd_idex | output | 2 | Command for decode/execute register |
| cmd_exmem | output | 2 | Command for execute/memory register |
| cmd_memwb | output | 2 | Command for memory/write-back register |
| pc_hold | output | 1 | Keep the program counter |
| pc_redirect | output | 1 | Load the branch target into the program counter |

## Verification
The two functions that can collide are the load-use interlock and the taken-branch cancel: a load sitting in execute that feeds the decode instruction while a taken branch sits in memory. The bench builds this case on purpose (and hits it again in a random phase with a narrow register range) and expects the cancel pattern with `pc_redirect` high and `pc_hold` low, never a stall. A behavioural model of both the forwarding and the no-forwarding variants judges every cycle.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
   typedef enum logic [1:0] {
      PR_XFER = 2'b00,
      PR_HOLD = 2'b01,
      PR_NOP  = 2'b10
   } preg_cmd_e;
endpackage

// File: rtl/pipe_src_match.sv
// Compares the decode-stage sources with pending writers.
// BYPASS selects the interlock rule: forwarding present (loads only)
// or absent (any pending writer in execute or memory).
module pipe_src_match #(
   parameter int REG_W    = 5,
   parameter int ZERO_REG = 31,
   parameter bit BYPASS   = 1'b1
) (
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   input  logic             use_a,
   input  logic             use_b,
   input  logic             ex_wr,
   input  logic             ex_load,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] mem_dst,
   output logic             need_stall
);
   localparam int NSRC = 2;
   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

   logic [REG_W-1:0] src [NSRC];
   logic [NSRC-1:0]  used;
   logic [NSRC-1:0]  hit_ex;
   logic [NSRC-1:0]  hit_mem;
   logic             ex_live;
   logic             mem_live;

   assign src[0]   = src_a;
   assign src[1]   = src_b;
   assign used     = {use_b, use_a};
   assign ex_live  = ex_wr  && (ex_dst  != ZR);
   assign mem_live = mem_wr && (mem_dst != ZR);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit_ex[i]  = used[i] && ex_live  && (src[i] == ex_dst);
      assign hit_mem[i] = used[i] && mem_live && (src[i] == mem_dst);
   end

   if (BYPASS) begin : g_fwd
      logic unused_mem;
      assign unused_mem = ^hit_mem;
      assign need_stall = ex_load && (|hit_ex);
   end else begin : g_nofwd
      logic unused_ld;
      assign unused_ld  = ex_load;
      assign need_stall = (|hit_ex) || (|hit_mem);
   end
endmodule

// File: rtl/pipe_cmd_merge.sv
// Turns interlock and cancel requests into per-register commands.
module pipe_cmd_merge
   import pipe_ctl_pkg::*;
(
   input  logic      rst_n,
   input  logic      load_stall,
   input  logic      br_cancel,
   output preg_cmd_e c_ifid,
   output preg_cmd_e c_idex,
   output preg_cmd_e c_exmem,
   output preg_cmd_e c_memwb,
   output logic      pc_hold,
   output logic      pc_redirect
);
   always_comb begin
      c_ifid      = PR_XFER;
      c_idex      = PR_XFER;
      c_exmem     = PR_XFER;
      c_memwb     = PR_XFER;
      pc_hold     = 1'b0;
      pc_redirect = 1'b0;
      if (!rst_n) begin
         c_ifid  = PR_NOP;
         c_idex  = PR_NOP;
         c_exmem = PR_NOP;
         c_memwb = PR_NOP;
         pc_hold = 1'b1;
      end else if (br_cancel) begin
         c_ifid      = PR_NOP;
         c_idex      = PR_NOP;
         c_exmem     = PR_NOP;
         pc_redirect = 1'b1;
      end else if (load_stall) begin
         c_ifid  = PR_HOLD;
         c_idex  = PR_NOP;
         pc_hold = 1'b1;
      end
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
   parameter int IW       = 32,
   parameter int REG_W    = 5,
   parameter int RA_LSB   = 21,
   parameter int RB_LSB   = 16,
   parameter int ZERO_REG = 31,
   parameter bit BYPASS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    id_instr,
   input  logic             id_reads_a,
   input  logic             id_reads_b,
   input  logic             ex_wr,
   input  logic             ex_load,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_branch,
   input  logic             mem_taken,
   output logic [1:0]       cmd_ifid,
   output logic [1:0]       cmd_idex,
   output logic [1:0]       cmd_exmem,
   output logic [1:0]       cmd_memwb,
   output logic             pc_hold,
   output logic             pc_redirect
);
   import pipe_ctl_pkg::*;

   localparam int NREGS = 1 << REG_W;

   if (RA_LSB + REG_W > IW || RB_LSB + REG_W > IW) begin : g_bad_field
      $error("source field lies outside the instruction word");
   end
   if (ZERO_REG >= NREGS || ZERO_REG < 0) begin : g_bad_zero
      $error("zero register index out of range");
   end

   logic [REG_W-1:0] src_a;
   logic [REG_W-1:0] src_b;
   logic             load_stall;
   logic             br_cancel;
   preg_cmd_e        c_ifid, c_idex, c_exmem, c_memwb;

   assign src_a     = id_instr[RA_LSB +: REG_W];
   assign src_b     = id_instr[RB_LSB +: REG_W];
   assign br_cancel = mem_branch && mem_taken;

   pipe_src_match #(
      .REG_W(REG_W), .ZERO_REG(ZERO_REG), .BYPASS(BYPASS)
   ) u_match (
      .src_a(src_a), .src_b(src_b),
      .use_a(id_reads_a), .use_b(id_reads_b),
      .ex_wr(ex_wr), .ex_load(ex_load), .ex_dst(ex_dst),
      .mem_wr(mem_wr), .mem_dst(mem_dst),
      .need_stall(load_stall)
   );

   pipe_cmd_merge u_merge (
      .rst_n(rst_n), .load_stall(load_stall), .br_cancel(br_cancel),
      .c_ifid(c_ifid), .c_idex(c_idex), .c_exmem(c_exmem), .c_memwb(c_memwb),
      .pc_hold(pc_hold), .pc_redirect(pc_redirect)
   );

   assign cmd_ifid  = c_ifid;
   assign cmd_idex  = c_idex;
   assign cmd_exmem = c_exmem;
   assign cmd_memwb = c_memwb;
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
   parameter int IW       = 32,
   parameter int REG_W    = 5,
   parameter int RA_LSB   = 21,
   parameter int ZERO_REG = 31,
   parameter bit BYPASS   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IW-1:0]    id_instr,
   input logic             id_reads_a,
   input logic             ex_wr,
   input logic             ex_load,
   input logic [REG_W-1:0] ex_dst,
   input logic             mem_wr,
   input logic [REG_W-1:0] mem_dst,
   input logic             mem_branch,
   input logic             mem_taken,
   input logic [1:0]       cmd_ifid,
   input logic [1:0]       cmd_idex,
   input logic [1:0]       cmd_exmem,
   input logic [1:0]       cmd_memwb,
   input logic             pc_hold,
   input logic             pc_redirect
);
   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

   logic ld_use_a;
   logic quiet_zero;
   assign ld_use_a   = ex_wr && ex_load && id_reads_a && (ex_dst != ZR) &&
                       (id_instr[RA_LSB +: REG_W] == ex_dst);
   assign quiet_zero = (!ex_wr || ex_dst == ZR) && (!mem_wr || mem_dst == ZR);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_ALL_NOP: assert (cmd_ifid == 2'b10 && cmd_idex == 2'b10 &&
                                    cmd_exmem == 2'b10 && cmd_memwb == 2'b10 &&
                                    pc_hold && !pc_redirect); // R1
      end else begin
         AST_INSTR_KNOWN: assert (!$isunknown(id_instr)); // R9
      end
   end

   AST_TAKEN_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_branch && mem_taken) |-> (cmd_ifid == 2'b10 && cmd_idex == 2'b10 &&
       cmd_exmem == 2'b10 && cmd_memwb == 2'b00 && pc_redirect && !pc_hold)); // R6

   AST_CANCEL_BEATS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_branch && mem_taken && ld_use_a) |-> (cmd_ifid != 2'b01 && !pc_hold)); // R8

   AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_use_a && !(mem_branch && mem_taken)) |->
      (cmd_ifid == 2'b01 && cmd_idex == 2'b10 && cmd_exmem == 2'b00 && pc_hold)); // R2

   AST_ZERO_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_zero && !(mem_branch && mem_taken)) |->
      (cmd_ifid == 2'b00 && cmd_idex == 2'b00 && !pc_hold)); // R4

   AST_TAIL_ALWAYS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_memwb == 2'b00); // R9

   AST_NOT_TAKEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_branch && !mem_taken) |-> !pc_redirect); // R7

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ifid != 2'b11 && cmd_idex != 2'b11 && cmd_exmem != 2'b11)); // R1
endmodule

bind pipe_hazard_ctl pipe_hazard_chk #(
   .IW(IW), .REG_W(REG_W), .RA_LSB(RA_LSB), .ZERO_REG(ZERO_REG), .BYPASS(BYPASS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_reads_a(id_reads_a),
   .ex_wr(ex_wr), .ex_load(ex_load), .ex_dst(ex_dst),
   .mem_wr(mem_wr), .mem_dst(mem_dst),
   .mem_branch(mem_branch), .mem_taken(mem_taken),
   .cmd_ifid(cmd_ifid), .cmd_idex(cmd_idex), .cmd_exmem(cmd_exmem),
   .cmd_memwb(cmd_memwb), .pc_hold(pc_hold), .pc_redirect(pc_redirect)
);

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] id_instr = '0;
   logic        id_reads_a = 1'b0, id_reads_b = 1'b0;
   logic        ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0;
   logic [4:0]  ex_dst = '0, mem_dst = '0;
   logic        mem_branch = 1'b0, mem_taken = 1'b0;

   logic [1:0]  f0_ifid, f0_idex, f0_exmem, f0_memwb;
   logic        f0_hold, f0_redir;
   logic [1:0]  n0_ifid, n0_idex, n0_exmem, n0_memwb;
   logic        n0_hold, n0_redir;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;  // 125 MHz

   pipe_hazard_ctl u0 (
      .clk(clk), .rst_n(rst_n), .id_instr(id_instr),
      .id_reads_a(id_reads_a), .id_reads_b(id_reads_b),
      .ex_wr(ex_wr), .ex_load(ex_load), .ex_dst(ex_dst),
      .mem_wr(mem_wr), .mem_dst(mem_dst),
      .mem_branch(mem_branch), .mem_taken(mem_taken),
      .cmd_ifid(f0_ifid), .cmd_idex(f0_idex), .cmd_exmem(f0_exmem),
      .cmd_memwb(f0_memwb), .pc_hold(f0_hold), .pc_redirect(f0_redir)
   );

   pipe_hazard_ctl #(.BYPASS(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .id_instr(id_instr),
      .id_reads_a(id_reads_a), .id_reads_b(id_reads_b),
      .ex_wr(ex_wr), .ex_load(ex_load), .ex_dst(ex_dst),
      .mem_wr(mem_wr), .mem_dst(mem_dst),
      .mem_branch(mem_branch), .mem_taken(mem_taken),
      .cmd_ifid(n0_ifid), .cmd_idex(n0_idex), .cmd_exmem(n0_exmem),
      .cmd_memwb(n0_memwb), .pc_hold(n0_hold), .pc_redirect(n0_redir)
   );

   // Behavioural reference: returns {hold, redirect, ifid, idex, exmem, memwb}
   function automatic logic [9:0] model(input bit fwd, output string tag);
      int ra, rb;
      bit hit;
      ra = int'(id_instr[25:21]);
      rb = int'(id_instr[20:16]);
      hit = 0;
      if (!rst_n) begin
         tag = "R1";
         return {1'b1, 1'b0, 2'd2, 2'd2, 2'd2, 2'd2};
      end
      if (mem_branch && mem_taken) begin
         tag = "R6/R8";
         return {1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 2'd0};
      end
      if (ex_wr && ex_dst != 5'd31 && (fwd == 0 || ex_load)) begin
         if (id_reads_a && ra == int'(ex_dst)) hit = 1;
         if (id_reads_b && rb == int'(ex_dst)) hit = 1;
      end
      if (!fwd && mem_wr && mem_dst != 5'd31) begin
         if (id_reads_a && ra == int'(mem_dst)) hit = 1;
         if (id_reads_b && rb == int'(mem_dst)) hit = 1;
      end
      if (hit) begin
         tag = fwd ? "R2/R3" : "R10";
         return {1'b1, 1'b0, 2'd1, 2'd2, 2'd0, 2'd0};
      end
      tag = mem_branch ? "R7" : "R9/R3/R4/R5";
      return {1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0};
   endfunction

   task automatic compare(input string note);
      logic [9:0] e0, e1, a0, a1;
      string t0, t1;
      e0 = model(1'b1, t0);
      e1 = model(1'b0, t1);
      a0 = {f0_hold, f0_redir, f0_ifid, f0_idex, f0_exmem, f0_memwb};
      a1 = {n0_hold, n0_redir, n0_ifid, n0_idex, n0_exmem, n0_memwb};
      total++;
      if (a0 !== e0) begin
         bad++;
         $display("FAIL %s [%s] fwd: actual=%b expected=%b", t0, note, a0, e0);
      end
      total++;
      if (a1 !== e1) begin
         bad++;
         $display("FAIL %s [%s] nofwd: actual=%b expected=%b", t1, note, a1, e1);
      end
   endtask

   task automatic clear_inputs();
      id_instr = 32'h0; id_reads_a = 0; id_reads_b = 0;
      ex_wr = 0; ex_load = 0; ex_dst = 0;
      mem_wr = 0; mem_dst = 0; mem_branch = 0; mem_taken = 0;
   endtask

   task automatic mk_instr(input int a, input int b);
      id_instr = {6'h11, 5'(a), 5'(b), 16'h0480};
   endtask

   task automatic step(input string note);
      @(negedge clk);
      #2 compare(note);
   endtask

   initial begin : watchdog
      #(8 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      // R1: reset state
      clear_inputs();
      step("R1 reset idle");
      ex_wr = 1; ex_load = 1; ex_dst = 5'd3; id_reads_a = 1; mk_instr(3, 0);
      step("R1 reset masks load-use");
      @(negedge clk); rst_n = 1'b1;
      clear_inputs();
      step("R9 idle after reset");

      // R2: load-use on A
      mk_instr(4, 9); id_reads_a = 1; ex_wr = 1; ex_load = 1; ex_dst = 5'd4;
      step("R2 load feeds A");
      // R3: load-use on B only when B is read
      clear_inputs(); mk_instr(1, 7); id_reads_a = 1; id_reads_b = 1;
      ex_wr = 1; ex_load = 1; ex_dst = 5'd7;
      step("R3 load feeds B read");
      id_reads_b = 0;
      step("R3 B not read ignored");
      // R4: destination 31
      clear_inputs(); mk_instr(31, 31); id_reads_a = 1; id_reads_b = 1;
      ex_wr = 1; ex_load = 1; ex_dst = 5'd31; mem_wr = 1; mem_dst = 5'd31;
      step("R4 zero register");
      // R5 / R10: ALU in EX, writer in MEM
      clear_inputs(); mk_instr(2, 5); id_reads_a = 1; ex_wr = 1; ex_dst = 5'd2;
      step("R5/R10 alu in ex");
      clear_inputs(); mk_instr(6, 5); id_reads_b = 1; mem_wr = 1; mem_dst = 5'd5;
      step("R5/R10 writer in mem");
      clear_inputs(); mk_instr(6, 5); id_reads_a = 1; mem_wr = 1; mem_dst = 5'd5;
      step("R10 unread B vs mem");
      // R6: taken branch
      clear_inputs(); mem_branch = 1; mem_taken = 1;
      step("R6 taken cancel");
      // R7: not taken
      mem_taken = 0;
      step("R7 not taken");
      mem_branch = 0; mem_taken = 1;
      step("R7 taken flag alone");
      // R8: collision of cancel and load-use
      clear_inputs(); mk_instr(8, 0); id_reads_a = 1;
      ex_wr = 1; ex_load = 1; ex_dst = 5'd8; mem_branch = 1; mem_taken = 1;
      step("R8 cancel beats stall");
      mem_taken = 0;
      step("R8 not taken keeps stall");

      // Random mix with a narrow register range
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         mk_instr(int'($urandom_range(0, 3)) | ((($urandom % 5) == 0) ? 31 : 0),
                  int'($urandom_range(0, 3)));
         id_reads_a = 1'($urandom);
         id_reads_b = 1'($urandom);
         ex_wr      = 1'($urandom);
         ex_load    = 1'($urandom);
         ex_dst     = (($urandom % 6) == 0) ? 5'd31 : 5'($urandom_range(0, 3));
         mem_wr     = 1'($urandom);
         mem_dst    = 5'($urandom_range(0, 3));
         mem_branch = (($urandom % 4) == 0);
         mem_taken  = 1'($urandom);
         rst_n      = (($urandom % 50) != 0);
         #2 compare("random R2 R6 R8 R10");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule